// File: doc/BRIEF.md
# Flash Page-to-Buffer Transfer Sequencer

This block is an SPI master that tells a serial flash to copy one page of its main array into one of the flash's two internal SRAM buffers, and then waits until the flash has finished. A single-cycle `start_i` pulse captures a 13-bit page number, a buffer select and a page-size mode. The sequencer then pulls chip select low and shifts out an opcode byte and three address bytes. It raises chip select, which is the event that starts the copy inside the flash. After that it reads the status byte repeatedly until the ready bit is set, and then signals `done_o` for one cycle.

The SPI link runs in mode 0. SCK idles low, MOSI changes after a falling edge and MISO is sampled on the rising edge. Every byte is sent MSB first, and address bits that the flash ignores are sent as zero. SCK runs at the system clock divided by `2*SCK_HALF_DIV`. Chip select stays high for at least `CS_GAP` system clocks (two or more) before each status frame.

The controller has five states. IDLE waits for `start_i` and goes to CMD. CMD shifts four bytes. After the fourth byte it goes to GAP, where chip select is high. GAP counts `CS_GAP` cycles and goes to POLL. POLL shifts the status opcode and reads one byte. It goes to DONE when bit 7 of that byte is 1, and back to GAP when bit 7 is 0. DONE lasts one cycle and returns to IDLE.

Top module: `flash_xfer_seq`

## Requirements
- R1: After reset `spi_cs_n_o` is 1, `spi_sck_o` is 0, and `busy_o` and `done_o` are 0.
- R2: The first byte of the command frame is 0x53 when `buf_sel_i`=0 and 0x55 when `buf_sel_i`=1. All bytes go out MSB first in SPI mode 0, so SCK is low whenever chip select falls and MOSI holds steady across every rising SCK edge.
- R3: With `bin_page_i`=0 (528-byte pages), the 24 address bits after the opcode are {1'b0, page[12:0], 10'b0}.
- R4: With `bin_page_i`=1 (512-byte pages), the 24 address bits after the opcode are {2'b00, page[12:0], 9'b0}.
- R5: The command frame is exactly 32 SCK cycles with chip select held low throughout. SCK stays low whenever chip select is high.
- R6: Chip select stays high for at least `CS_GAP` (default 2) system clocks between any frame and the next status frame.
- R7: Each status frame is 16 SCK cycles. Its first byte is 0xD7. Its second byte is read from MISO MSB first, and only bit 7 of that byte is used (1 = ready).
- R8: While the status byte reads bit 7 = 0, a new status frame is issued. The flash is therefore selected exactly 2 + (number of busy replies) times per request.
- R9: `done_o` is a one-cycle pulse in the cycle after the status frame that reads ready. During that cycle chip select is high and `busy_o` is 0.
- R10: `start_i` has no effect while `busy_o` or `done_o` is 1. The captured page, buffer and mode stay in use until the request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request pulse, sampled in IDLE |
| page_i | input | 13 | Main-array page number to copy |
| buf_sel_i | input | 1 | Target buffer: 0 = first, 1 = second |
| bin_page_i | input | 1 | Page-size mode: 0 = 528-byte, 1 = 512-byte |
| busy_o | output | 1 | High from the cycle after the accepted start until DONE |
| done_o | output | 1 | One-cycle completion pulse |
| spi_sck_o | output | 1 | SPI clock, idle low |
| spi_mosi_o | output | 1 | SPI data to the flash |
| spi_miso_i | input | 1 | SPI data from the flash |
| spi_cs_n_o | output | 1 | SPI chip select, active low |

## Verification
A wrong byte index or a bad state transition changes the number of SCK cycles between chip-select edges. The first frame that goes wrong shows this, well before `done_o`. A mis-latched request or a wrong packing mode puts the wrong opcode or address bits into the 32-bit command frame, and the bench compares that frame bit by bit once the request completes. A broken ready decision adds or drops status frames, or ends the request early. The count of selects per request catches either case within one poll period.

// File: rtl/flash_xfer_pkg.sv
package flash_xfer_pkg;

    localparam int PAGE_W    = 13;
    localparam int ADDR_W    = 24;
    localparam int BYTE_W    = 8;
    localparam int READY_BIT = 7;

    localparam logic [BYTE_W-1:0] OPC_COPY_BUF0 = 8'h53;
    localparam logic [BYTE_W-1:0] OPC_COPY_BUF1 = 8'h55;
    localparam logic [BYTE_W-1:0] OPC_STATUS    = 8'hD7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_POLL,
        ST_DONE
    } seq_state_t;

    // Page number placement differs by page-size mode; unused bits are zero.
    function automatic logic [ADDR_W-1:0] pack_addr(input logic [PAGE_W-1:0] page,
                                                     input logic            bin_mode);
        logic [ADDR_W-1:0] a;
        if (bin_mode) a = {2'b00, page, 9'b0};
        else          a = {1'b0,  page, 10'b0};
        return a;
    endfunction

endpackage

// File: rtl/flash_sck_tick.sv
module flash_sck_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (!en_i || cnt_q == LAST) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/flash_byte_shifter.sv
module flash_byte_shifter
    import flash_xfer_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [BYTE_W-1:0] tx_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              active_o,
    output logic              done_o,
    output logic [BYTE_W-1:0] rx_o
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic              tick;
    logic [BYTE_W-1:0] tx_sr_q;
    logic [BYTE_W-1:0] rx_sr_q;
    logic [BIT_W-1:0]  bit_q;
    logic              sck_q;
    logic              active_q;

    flash_sck_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (active_q),
        .tick_o (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr_q  <= '0;
            rx_sr_q  <= '0;
            bit_q    <= '0;
            sck_q    <= 1'b0;
            active_q <= 1'b0;
        end else if (go_i && !active_q) begin
            tx_sr_q  <= tx_i;
            bit_q    <= '0;
            sck_q    <= 1'b0;
            active_q <= 1'b1;
        end else if (active_q && tick) begin
            if (!sck_q) begin
                sck_q   <= 1'b1;
                rx_sr_q <= {rx_sr_q[BYTE_W-2:0], miso_i};
            end else begin
                sck_q   <= 1'b0;
                tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
                bit_q   <= bit_q + 1'b1;
                if (bit_q == LAST_BIT) active_q <= 1'b0;
            end
        end
    end

    assign sck_o    = sck_q;
    assign mosi_o   = tx_sr_q[BYTE_W-1];
    assign active_o = active_q;
    assign done_o   = active_q && tick && sck_q && (bit_q == LAST_BIT);
    assign rx_o     = rx_sr_q;

    // R2: data presented to the flash does not move on a rising SCK edge
    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> $stable(mosi_o));

    // R5: a byte ends with SCK back low
    assert_byte_end_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !sck_o);

endmodule

// File: rtl/flash_xfer_seq.sv
module flash_xfer_seq
    import flash_xfer_pkg::*;
#(
    parameter int SCK_HALF_DIV = 2,
    parameter int CS_GAP       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              buf_sel_i,
    input  logic              bin_page_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              spi_sck_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i,
    output logic              spi_cs_n_o
);
    localparam int GAP_W = $clog2(CS_GAP + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
    localparam logic [1:0] CMD_LAST  = 2'd3;
    localparam logic [1:0] POLL_LAST = 2'd1;

    seq_state_t        state_q, state_d;
    logic [1:0]        idx_q, idx_d;
    logic [GAP_W-1:0]  gap_q, gap_d;
    logic [PAGE_W-1:0] page_q;
    logic              buf_q;
    logic              bin_q;

    logic              sh_go;
    logic              sh_active;
    logic              sh_done;
    logic [BYTE_W-1:0] sh_tx;
    logic [BYTE_W-1:0] sh_rx;
    logic [ADDR_W-1:0] addr_w;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && start_i;
    assign addr_w = pack_addr(page_q, bin_q);

    flash_byte_shifter #(.HALF_DIV(SCK_HALF_DIV)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (sh_go),
        .tx_i     (sh_tx),
        .miso_i   (spi_miso_i),
        .sck_o    (spi_sck_o),
        .mosi_o   (spi_mosi_o),
        .active_o (sh_active),
        .done_o   (sh_done),
        .rx_o     (sh_rx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        gap_d   = gap_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_CMD;
                    idx_d   = '0;
                end
            end
            ST_CMD: begin
                if (sh_done) begin
                    if (idx_q == CMD_LAST) begin
                        state_d = ST_GAP;
                        gap_d   = '0;
                    end else begin
                        idx_d = idx_q + 2'd1;
                    end
                end
            end
            ST_GAP: begin
                if (gap_q == GAP_LAST) begin
                    state_d = ST_POLL;
                    idx_d   = '0;
                end else begin
                    gap_d = gap_q + 1'b1;
                end
            end
            ST_POLL: begin
                if (sh_done) begin
                    if (idx_q == POLL_LAST) begin
                        if (sh_rx[READY_BIT]) begin
                            state_d = ST_DONE;
                        end else begin
                            state_d = ST_GAP;
                            gap_d   = '0;
                        end
                    end else begin
                        idx_d = idx_q + 2'd1;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            gap_q   <= gap_d;
        end
    end

    // Request capture: only when idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            buf_q  <= 1'b0;
            bin_q  <= 1'b0;
        end else if (accept) begin
            page_q <= page_i;
            buf_q  <= buf_sel_i;
            bin_q  <= bin_page_i;
        end
    end

    // Outputs
    always_comb begin
        spi_cs_n_o = 1'b1;
        sh_go      = 1'b0;
        sh_tx      = '0;
        busy_o     = 1'b0;
        done_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CMD: begin
                spi_cs_n_o = 1'b0;
                busy_o     = 1'b1;
                sh_go      = !sh_active;
                case (idx_q)
                    2'd0:    sh_tx = buf_q ? OPC_COPY_BUF1 : OPC_COPY_BUF0;
                    2'd1:    sh_tx = addr_w[23:16];
                    2'd2:    sh_tx = addr_w[15:8];
                    default: sh_tx = addr_w[7:0];
                endcase
            end
            ST_GAP: busy_o = 1'b1;
            ST_POLL: begin
                spi_cs_n_o = 1'b0;
                busy_o     = 1'b1;
                sh_go      = !sh_active;
                sh_tx      = (idx_q == 2'd0) ? OPC_STATUS : '0;
            end
            ST_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    // R5: SCK never toggles with the flash deselected
    assert_sck_low_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sck_o);

    // R6: a deselect lasts more than one cycle
    assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n_o) |=> spi_cs_n_o);

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: completion only with the flash deselected and not busy
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (spi_cs_n_o && !busy_o));

    // R10: captured request holds while a request is running
    assert_ignore_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || done_o) |=> ($stable(page_q) && $stable(buf_q) && $stable(bin_q)));

endmodule

// File: tb/flash_xfer_seq_bench.sv
module flash_xfer_seq_bench;

    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] page = '0;
    logic        buf_sel = 1'b0;
    logic        bin_mode = 1'b0;
    logic        busy, done, sck, mosi, miso, cs_n;

    always #4 clk = ~clk;

    flash_xfer_seq u_flash_xfer_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .page_i     (page),
        .buf_sel_i  (buf_sel),
        .bin_page_i (bin_mode),
        .busy_o     (busy),
        .done_o     (done),
        .spi_sck_o  (sck),
        .spi_mosi_o (mosi),
        .spi_miso_i (miso),
        .spi_cs_n_o (cs_n)
    );

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit wd = 1'b0;

    // flash model and frame monitor state
    logic [15:0] out_sr = '0;
    logic [31:0] fr_data;
    int          fr_bits;
    bit          in_frame = 1'b0;
    int          txn_frame = 0;
    int          busy_polls = 0;
    logic [7:0]  busy_pat = 8'h00;
    logic [7:0]  ready_pat = 8'h80;
    int          nfr = 0;
    logic [31:0] rec_data [0:63];
    int          rec_bits [0:63];
    int          min_gap = 1000;
    int          gap_run = 0;
    bit          sck_bad = 1'b0;
    int          done_cnt = 0;
    bit          done_dbl = 1'b0;
    logic        prev_done = 1'b0;

    assign miso = out_sr[15];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_opc(input bit b);
        return b ? 8'h55 : 8'h53;
    endfunction

    function automatic logic [23:0] exp_addr(input logic [12:0] p, input bit m);
        logic [23:0] a;
        a = '0;
        if (m) a[21:9]  = p;
        else   a[22:10] = p;
        return a;
    endfunction

    always @(posedge clk) cyc++;

    always @(negedge cs_n) begin : sel_fall
        int j;
        if (rst_n === 1'b1) begin
            in_frame = 1'b1;
            fr_bits  = 0;
            fr_data  = '0;
            if (sck !== 1'b0) sck_bad = 1'b1;
            if (nfr > 0 && gap_run < min_gap) min_gap = gap_run;
            if (txn_frame >= 1) begin
                j = txn_frame - 1;
                out_sr = {8'h00, (j >= busy_polls) ? ready_pat : busy_pat};
            end else begin
                out_sr = '0;
            end
        end
    end

    always @(posedge sck) if (in_frame) begin
        fr_data = {fr_data[30:0], mosi};
        fr_bits++;
    end

    always @(negedge sck) if (in_frame) out_sr = {out_sr[14:0], 1'b0};

    always @(posedge cs_n) if (in_frame) begin
        in_frame = 1'b0;
        if (nfr < 64) begin
            rec_data[nfr] = fr_data;
            rec_bits[nfr] = fr_bits;
        end
        nfr++;
        txn_frame++;
    end

    always @(negedge clk) if (rst_n) begin
        if (cs_n === 1'b1) gap_run++;
        else               gap_run = 0;
        if (done) done_cnt++;
        if (done && prev_done) done_dbl = 1'b1;
        prev_done = done;
    end

    task automatic run_txn(input logic [12:0] pg, input bit bs, input bit bm, input int polls,
                           input logic [7:0] bpat, input logic [7:0] rpat, input bit poke);
        logic [31:0] exp_cmd;
        busy_polls = polls;
        busy_pat   = bpat & 8'h7F;
        ready_pat  = rpat | 8'h80;
        txn_frame  = 0;
        nfr        = 0;
        min_gap    = 1000;
        done_cnt   = 0;
        done_dbl   = 1'b0;
        sck_bad    = 1'b0;
        @(negedge clk);
        page = pg; buf_sel = bs; bin_mode = bm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", {31'b0, busy}, 32'd1);
        if (poke) begin
            repeat (20) @(negedge clk);
            page = ~pg; buf_sel = ~bs; bin_mode = ~bm; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0 && !wd) begin
            @(negedge clk);
            if (cyc > WD_LIMIT) wd = 1'b1;
        end
        repeat (3) @(negedge clk);
        exp_cmd = {exp_opc(bs), exp_addr(pg, bm)};
        check(nfr == polls + 2, "R8 select count", nfr, polls + 2);
        check(rec_bits[0] == 32, "R5 command frame bits", rec_bits[0], 32);
        check(rec_data[0][31:24] == exp_cmd[31:24], "R2 opcode", rec_data[0][31:24], exp_cmd[31:24]);
        check(rec_data[0][23:0] == exp_cmd[23:0], bm ? "R4 address 512" : "R3 address 528",
              rec_data[0][23:0], exp_cmd[23:0]);
        if (poke) check(rec_data[0] == exp_cmd, "R10 start ignored", rec_data[0], exp_cmd);
        for (int i = 1; i < nfr && i < 64; i++) begin
            check(rec_bits[i] == 16, "R7 status frame bits", rec_bits[i], 16);
            check(rec_data[i][15:8] == 8'hD7, "R7 status opcode", rec_data[i][15:8], 8'hD7);
        end
        check(min_gap >= 2, "R6 deselect gap", min_gap, 2);
        check(done_cnt == 1 && !done_dbl, "R9 done pulse", done_cnt, 1);
        check(busy == 1'b0 && cs_n == 1'b1, "R9 idle after done", {30'b0, busy, cs_n}, 32'd1);
        check(!sck_bad, "R2 SCK low at select", {31'b0, sck_bad}, 32'd0);
    endtask

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1 && sck === 1'b0, "R1 SPI pins in reset", {30'b0, cs_n, sck}, 32'd2);
        check(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {30'b0, busy, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n === 1'b1 && busy === 1'b0, "R1 idle after reset", {30'b0, cs_n, busy}, 32'd2);

        // directed corners
        run_txn(13'h0000, 1'b0, 1'b0, 0, 8'h00, 8'h80, 1'b0);
        run_txn(13'h1FFF, 1'b1, 1'b0, 1, 8'h7F, 8'h80, 1'b0);
        run_txn(13'h1FFF, 1'b0, 1'b1, 2, 8'h7F, 8'hFF, 1'b0);
        run_txn(13'h0001, 1'b1, 1'b1, 3, 8'h55, 8'h80, 1'b1);
        run_txn(13'h1000, 1'b0, 1'b0, 0, 8'h00, 8'h80, 1'b1);

        // random mix
        for (int k = 0; k < 12 && !wd; k++) begin
            run_txn(13'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 5),
                    8'($urandom), 8'($urandom), 1'($urandom));
        end

        if (wd) begin
            fails++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : guard
        #(8 * 190000);
        fails++;
        vectors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, WD_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule